// File: doc/BRIEF.md
# Conversion Result Output Latch with Ready Flag

This block keeps the last finished 16-bit conversion result in a holding register that is apart from the conversion logic. A host reads that word through an 8-bit port, one byte at a time, while the next conversion runs. A one-cycle completion pulse loads a new word and raises a ready flag. The flag stays high until the host finishes reading the upper byte.

The host chooses the byte with a lane select. It opens the port with chip select and read held high together. When the port is not open, the output-enable is low and the data lines are parked at zero. This stands in for a high-impedance bus. A bipolar flag and a format select together pick offset binary or two's complement on the port. The stored word is never changed by the format setting.

Top module: `conv_out_latch`

## Requirements
- R1: With the port open, `hi_sel`=1 puts bits 15..8 of the formatted word on `bus_data` and `hi_sel`=0 puts bits 7..0, in the same cycle.
- R2: `bus_oe` is high exactly when `cs` and `rd` are both high. While it is low, `bus_data` is all zeros.
- R3: A high `cnv_done` at a rising clock edge loads `cnv_word` into the latch and sets `data_ready`, both visible after that edge.
- R4: A high-byte access is a cycle with `cs`, `rd` and `hi_sel` all high. `data_ready` clears at the first edge where that condition no longer holds after it held, so the byte stays stable for the whole access.
- R5: Low-byte reads, and cycles without any read, leave `data_ready` unchanged.
- R6: A completion pulse that arrives while `data_ready` is already high overwrites the latch with the new word, and `data_ready` stays high.
- R7: Without a completion pulse, the latched word and the byte presented on the port do not change.
- R8: When `bipolar`=1 and `twos_sel`=1, bit 15 of the word on the port is inverted, which gives two's complement. In every other combination the word passes unchanged.
- R9: Reset (`rst_n`=0) clears the latch to zero and clears `data_ready`.
- R10: If a completion pulse lands in the same cycle that a high-byte access ends, the new word is loaded and `data_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnv_done | input | 1 | One-cycle pulse: conversion result valid |
| cnv_word | input | 16 | Finished conversion result |
| bipolar | input | 1 | Data is from a bipolar input range |
| twos_sel | input | 1 | 1 = two's complement output for bipolar data |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| hi_sel | input | 1 | 1 = upper byte, 0 = lower byte |
| bus_data | output | 8 | Byte on the port; zero when not enabled |
| bus_oe | output | 1 | Port drive enable |
| data_ready | output | 1 | An unread new word is held |

## Verification
`bus_oe` and `bus_data` follow `cs`, `rd`, `hi_sel` and the format inputs in the same cycle. A completion pulse shows on `data_ready` and the port one rising edge later. The flag clears one edge after the cycle in which a high-byte access ends. The bench changes inputs on the falling edge and moves its reference model on the rising edge. It compares the outputs on the next falling edge, so every result is sampled in the cycle it is due.

// File: rtl/olat_pkg.sv
package olat_pkg;

    // Flag state kept beside the latched word
    typedef struct packed {
        logic rdy;     // unread word present
        logic hi_acc;  // upper-byte access active last cycle
    } flag_t;

    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

endpackage

// File: rtl/olat_hold.sv
module olat_hold #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_done,
    input  logic [WORD_W-1:0] cnv_word,
    input  logic              hi_access,
    output logic [WORD_W-1:0] word_q,
    output logic              rdy_q
);
    import olat_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        flag_t             flg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.flg.hi_acc = hi_access;
        if (cnv_done) begin
            st_d.word    = cnv_word;
            st_d.flg.rdy = 1'b1;
        end else if (st_q.flg.hi_acc && !hi_access) begin
            st_d.flg.rdy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_q = st_q.word;
    assign rdy_q  = st_q.flg.rdy;

    AST_LOAD_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_done |=> (rdy_q && word_q == $past(cnv_word))); // R3

    AST_HI_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flg.hi_acc && !hi_access && !cnv_done) |=> !rdy_q); // R4

    AST_NO_HI_END_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_q && !(st_q.flg.hi_acc && !hi_access)) |=> rdy_q); // R5

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_done |=> $stable(word_q)); // R7

    AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_done && st_q.flg.hi_acc && !hi_access) |=> rdy_q); // R10

endmodule

// File: rtl/olat_fmt.sv
module olat_fmt #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic              bipolar,
    input  logic              twos_sel,
    output logic [WORD_W-1:0] word_out
);
    localparam int SIGN_BIT = WORD_W - 1;

    logic flip_sign;
    assign flip_sign = bipolar & twos_sel;

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        if (b == SIGN_BIT) begin : g_sign
            assign word_out[b] = word_in[b] ^ flip_sign;
        end else begin : g_pass
            assign word_out[b] = word_in[b];
        end
    end

endmodule

// File: rtl/olat_lane.sv
module olat_lane #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              lane_sel,
    input  logic              port_open,
    output logic [BYTE_W-1:0] bus_data,
    output logic              bus_oe
);
    import olat_pkg::*;

    localparam int NLANES = WORD_W / BYTE_W;

    logic [BYTE_W-1:0] lanes [NLANES];

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        assign lanes[l] = word[l*BYTE_W +: BYTE_W];
    end

    lane_e pick;
    assign pick = lane_e'(lane_sel);

    always_comb begin
        bus_oe   = port_open;
        bus_data = '0;
        if (port_open) begin
            bus_data = (pick == LANE_HI) ? lanes[NLANES-1] : lanes[0];
        end
    end

    AST_CLOSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_data == '0)); // R2

endmodule

// File: rtl/conv_out_latch.sv
module conv_out_latch #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_done,
    input  logic [WORD_W-1:0] cnv_word,
    input  logic              bipolar,
    input  logic              twos_sel,
    input  logic              cs,
    input  logic              rd,
    input  logic              hi_sel,
    output logic [BYTE_W-1:0] bus_data,
    output logic              bus_oe,
    output logic              data_ready
);
    logic              port_open;
    logic              hi_access;
    logic [WORD_W-1:0] held_word;
    logic [WORD_W-1:0] shown_word;

    assign port_open = cs & rd;
    assign hi_access = port_open & hi_sel;

    olat_hold #(.WORD_W(WORD_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnv_done  (cnv_done),
        .cnv_word  (cnv_word),
        .hi_access (hi_access),
        .word_q    (held_word),
        .rdy_q     (data_ready)
    );

    olat_fmt #(.WORD_W(WORD_W)) u_fmt (
        .word_in  (held_word),
        .bipolar  (bipolar),
        .twos_sel (twos_sel),
        .word_out (shown_word)
    );

    olat_lane #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .word      (shown_word),
        .lane_sel  (hi_sel),
        .port_open (port_open),
        .bus_data  (bus_data),
        .bus_oe    (bus_oe)
    );

    AST_OE_FOLLOWS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd) |-> bus_oe); // R2

endmodule

// File: tb/conv_out_latch_test.sv
`timescale 1ns/1ps
module conv_out_latch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnv_done = 1'b0;
    logic [15:0] cnv_word = '0;
    logic        bipolar = 1'b0;
    logic        twos_sel = 1'b0;
    logic        cs = 1'b0;
    logic        rd = 1'b0;
    logic        hi_sel = 1'b0;
    logic [7:0]  bus_data;
    logic        bus_oe;
    logic        data_ready;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_word = '0;
    logic        m_rdy = 1'b0;
    logic        m_hiacc = 1'b0;

    always #2.5 clk = ~clk;

    conv_out_latch uut (
        .clk(clk), .rst_n(rst_n), .cnv_done(cnv_done), .cnv_word(cnv_word),
        .bipolar(bipolar), .twos_sel(twos_sel), .cs(cs), .rd(rd),
        .hi_sel(hi_sel), .bus_data(bus_data), .bus_oe(bus_oe),
        .data_ready(data_ready)
    );

    function automatic logic [7:0] exp_byte(input logic [15:0] w, input logic hi,
                                            input logic bip, input logic tw,
                                            input logic open);
        logic [15:0] f;
        f = w ^ ((bip && tw) ? 16'h8000 : 16'h0000);
        if (!open) return 8'h00;
        return hi ? f[15:8] : f[7:0];
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: model advances at the rising edge, outputs compared at the falling edge
    task automatic cyc(input string tag);
        logic now_hi;
        @(posedge clk);
        now_hi = cs && rd && hi_sel;
        if (!rst_n) begin
            m_word = '0; m_rdy = 1'b0; m_hiacc = 1'b0;
        end else begin
            if (cnv_done) begin
                m_word = cnv_word; m_rdy = 1'b1;
            end else if (m_hiacc && !now_hi) begin
                m_rdy = 1'b0;
            end
            m_hiacc = now_hi;
        end
        @(negedge clk);
        check({tag, " ready"}, {15'd0, data_ready}, {15'd0, m_rdy});
        check("R2 oe", {15'd0, bus_oe}, {15'd0, cs && rd});
        check({tag, " bus R1"}, {8'd0, bus_data},
              {8'd0, exp_byte(m_word, hi_sel, bipolar, twos_sel, cs && rd)});
    endtask

    task automatic drive(input logic c, input logic r, input logic h,
                         input logic d, input logic [15:0] w);
        cs = c; rd = r; hi_sel = h; cnv_done = d; cnv_word = w;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        @(negedge clk);
        rst_n = 1'b0;
        cyc("R9 reset");
        cyc("R9 reset");
        drive(1, 1, 1, 0, 16'h0);
        cyc("R9 reset read");
        drive(0, 0, 0, 0, 16'h0);
        rst_n = 1'b1;
        cyc("R2 idle");

        // R3 load and set ready
        drive(0, 0, 0, 1, 16'hA55A);
        cyc("R3 load");
        // R5 low-byte read keeps ready; R7 word held
        drive(1, 1, 0, 0, 16'h1111);
        cyc("R5 low read");
        cyc("R5 low read");
        drive(0, 0, 0, 0, 16'h2222);
        cyc("R5 after low read");
        cyc("R7 held");
        // R6 overwrite while ready
        drive(0, 0, 0, 1, 16'h1234);
        cyc("R6 overwrite");
        drive(0, 0, 0, 0, 16'h0);
        cyc("R6 still ready");
        // R4 high-byte access: ready holds through access, clears after end
        drive(1, 1, 1, 0, 16'h0);
        cyc("R4 during hi access");
        cyc("R4 during hi access");
        drive(0, 0, 1, 0, 16'h0);
        cyc("R4 after hi access");
        cyc("R4 stays clear");
        // R8 format combinations
        drive(0, 0, 0, 1, 16'h8001);
        cyc("R3 load");
        for (int k = 0; k < 4; k++) begin
            bipolar = k[0]; twos_sel = k[1];
            drive(1, 1, 1, 0, 16'h0);
            cyc("R8 format hi");
            drive(1, 1, 0, 0, 16'h0);
            cyc("R8 format lo");
        end
        // R10 completion in the cycle a high access ends
        drive(0, 0, 0, 1, 16'h00FF);
        cyc("R3 load");
        drive(1, 1, 1, 0, 16'h0);
        cyc("R10 hi access");
        drive(0, 0, 0, 1, 16'hBEEF);
        cyc("R10 collide");
        drive(0, 0, 0, 0, 16'h0);
        cyc("R10 after collide");
        // R9 reset mid-run with data held
        rst_n = 1'b0;
        cyc("R9 mid reset");
        rst_n = 1'b1;
        drive(1, 1, 1, 0, 16'h0);
        cyc("R9 latch zero");

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            drive(($urandom % 4) != 0, ($urandom % 3) != 0, $urandom % 2,
                  ($urandom % 8) == 0, 16'($urandom));
            bipolar  = $urandom % 2;
            twos_sel = $urandom % 2;
            cyc("R4 R5 R6 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule